// File: doc/BRIEF.md
# Masked Vector Scatter Store Sequencer

This block turns one vector scatter command into a series of single-element memory writes. A command carries a base address, a signed displacement, a scale code, a packed index vector, a packed data vector, a write mask and a mode. The mode picks the index width (32 or 64 bits), the element width (32 or 64 bits) and the vector length (128, 256 or 512 bits). Together these settle how many elements the command covers.

The sequencer visits the enabled elements from the lowest index upward. For each one it computes the target address and issues one write, with byte enables, on a valid/ready port. It then waits for an OK or fault response before it moves on. Each OK response clears that element's mask bit. A fault stops the run and leaves the remaining mask bits set, so the command can be restarted from where it stopped. A few illegal encodings are rejected before any write is issued.

Top module: `vscatter_seq`

## Requirements
- R1: The element count KL is 4, 8 or 16 for vlen_i codes 0, 1 and 2 when idx64_i=0 and elem64_i=0. For every other pairing of those two inputs it is 2, 4 or 8. Only elements 0..KL-1 are ever written.
- R2: Element j is written at base_i + (index << scale_i) + sign-extended disp_i. A 32-bit index is word j of index_i, sign-extended. A 64-bit index is words 2j+1:2j of index_i, used as is. scale_i codes 0..3 mean factors 1, 2, 4 and 8.
- R3: The write address is the low AW bits of that sum. Higher bits are dropped.
- R4: Only elements whose mask bit is 1 are written, strictly in ascending element order. At most one write is outstanding, and the next write is offered only after the previous response. wr_valid_o stays high with a stable address and data until wr_ready_i is accepted.
- R5: A 32-bit element puts data word j in wr_data_o[31:0], zero in the upper half, and drives wr_be_o=8'h0F. A 64-bit element puts words 2j+1:2j on wr_data_o and drives wr_be_o=8'hFF.
- R6: An OK response clears that element's mask bit. On completion, done_o pulses for one cycle and mask_o is all zero, including bits KL and above. Mask bits are never set while the block is busy.
- R7: A fault response pulses fault_o for one cycle and sets fault_elem_o to the faulting element. No further writes follow. mask_o keeps the bits of the faulting element and of all higher positions, and only the enabled elements below it are cleared.
- R8: A start with kreg_zero_i=1, with zeroing_i=1, or with vlen_i=3 pulses illegal_o one cycle later. It issues no writes and loads mask_o with mask_i unchanged.
- R9: With no mask bit set below KL, done_o pulses two cycles after the start cycle, no write is issued and mask_o ends at zero.
- R10: busy_o is high from the cycle after an accepted start until the end pulse. A start that arrives while busy_o is high is ignored.
- R11: After reset, busy_o, done_o, fault_o, illegal_o and wr_valid_o are low and mask_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| idx64_i | input | 1 | 1: 64-bit indices |
| elem64_i | input | 1 | 1: 64-bit elements |
| vlen_i | input | 2 | Vector length code: 0=128, 1=256, 2=512, 3 illegal |
| scale_i | input | 2 | Index scale, log2 |
| kreg_zero_i | input | 1 | Mask register 0 was selected (illegal) |
| zeroing_i | input | 1 | Zeroing control set (illegal) |
| base_i | input | 64 | Base address |
| disp_i | input | 32 | Signed displacement |
| index_i | input | MAX_KL*32 | Packed index vector |
| data_i | input | MAX_KL*32 | Packed data vector |
| mask_i | input | MAX_KL | Write mask |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write request accepted |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 64 | Write data |
| wr_be_o | output | 8 | Byte enables |
| rsp_valid_i | input | 1 | Write response valid |
| rsp_fault_i | input | 1 | Response is a fault |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Completion pulse |
| fault_o | output | 1 | Fault pulse |
| fault_elem_o | output | $clog2(MAX_KL) | Element that faulted |
| illegal_o | output | 1 | Illegal encoding pulse |
| mask_o | output | MAX_KL | Current mask |

## Verification
The bench sweeps every index-width, element-width and length combination under several mask patterns, scales, and bases near the top of the address space. This catches a wrong element count, a missing sign extension, a shifted lane pairing or an untruncated address as a wrong write list. Faults are injected on the second write to show the effect of clearing the faulting bit, continuing past a fault or wiping the upper mask. Empty masks, stalled ready, and a second start while busy expose a design that scans slowly, loses a handshake or restarts mid-run. Illegal encodings check that no write escapes and that the mask stays as given.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_ISSUE, ST_WAIT} vsc_st_e;

  localparam logic [1:0] VLEN_BAD = 2'd3;
  localparam logic [7:0] BE_W32 = 8'h0F;
  localparam logic [7:0] BE_W64 = 8'hFF;
endpackage

// File: rtl/vsc_first_set.sv
module vsc_first_set #(
  parameter int N  = 16,
  parameter int PW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    found_o = 1'b0;
    pos_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        pos_o   = PW'(i);
      end
    end
  end
endmodule

// File: rtl/vsc_elem_path.sv
module vsc_elem_path
  import vsc_pkg::*;
#(
  parameter int MAX_KL = 16,
  parameter int AW     = 40,
  parameter int IW     = $clog2(MAX_KL)
) (
  input  logic [IW-1:0]        elem_i,
  input  logic                 idx64_i,
  input  logic                 elem64_i,
  input  logic [1:0]           scale_i,
  input  logic [63:0]          base_i,
  input  logic [31:0]          disp_i,
  input  logic [MAX_KL*32-1:0] index_i,
  input  logic [MAX_KL*32-1:0] data_i,
  output logic [AW-1:0]        addr_o,
  output logic [63:0]          data_o,
  output logic [7:0]           be_o
);
  logic [31:0] idx_w [MAX_KL];
  logic [31:0] dat_w [MAX_KL];

  for (genvar g = 0; g < MAX_KL; g++) begin : g_lane
    assign idx_w[g] = index_i[g*32 +: 32];
    assign dat_w[g] = data_i[g*32 +: 32];
  end

  logic [IW-1:0] lo_sel, hi_sel;
  logic [63:0]   ix, full;

  assign lo_sel = {elem_i[IW-2:0], 1'b0};
  assign hi_sel = {elem_i[IW-2:0], 1'b1};

  always_comb begin
    if (idx64_i) ix = {idx_w[hi_sel], idx_w[lo_sel]};
    else         ix = {{32{idx_w[elem_i][31]}}, idx_w[elem_i]};
    full = base_i + (ix << scale_i) + {{32{disp_i[31]}}, disp_i};
  end

  assign addr_o = full[AW-1:0];
  assign data_o = elem64_i ? {dat_w[hi_sel], dat_w[lo_sel]} : {32'h0, dat_w[elem_i]};
  assign be_o   = elem64_i ? BE_W64 : BE_W32;
endmodule

// File: rtl/vscatter_seq.sv
module vscatter_seq
  import vsc_pkg::*;
#(
  parameter int MAX_KL = 16,
  parameter int AW     = 40
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic                       idx64_i,
  input  logic                       elem64_i,
  input  logic [1:0]                 vlen_i,
  input  logic [1:0]                 scale_i,
  input  logic                       kreg_zero_i,
  input  logic                       zeroing_i,
  input  logic [63:0]                base_i,
  input  logic [31:0]                disp_i,
  input  logic [MAX_KL*32-1:0]       index_i,
  input  logic [MAX_KL*32-1:0]       data_i,
  input  logic [MAX_KL-1:0]          mask_i,
  output logic                       wr_valid_o,
  input  logic                       wr_ready_i,
  output logic [AW-1:0]              wr_addr_o,
  output logic [63:0]                wr_data_o,
  output logic [7:0]                 wr_be_o,
  input  logic                       rsp_valid_i,
  input  logic                       rsp_fault_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       fault_o,
  output logic [$clog2(MAX_KL)-1:0]  fault_elem_o,
  output logic                       illegal_o,
  output logic [MAX_KL-1:0]          mask_o
);
  localparam int VEC_W = MAX_KL * 32;
  localparam int IW    = $clog2(MAX_KL);
  localparam int KW    = IW + 1;

  vsc_st_e            st_q;
  logic [IW-1:0]      elem_q, felem_q, next_pos;
  logic [MAX_KL-1:0]  mask_q, kl_mask, live;
  logic [KW-1:0]      kl_q, kl_new;
  logic [63:0]        base_q;
  logic [31:0]        disp_q;
  logic [1:0]         scale_q;
  logic               idx64_q, elem64_q, any_live;
  logic [VEC_W-1:0]   index_q, data_q;
  logic               done_q, fault_q, illegal_q, bad_cmd;

  // narrow index and element both 32 bits -> full lane count, else half
  always_comb begin
    kl_new = (!idx64_i && !elem64_i) ? KW'(MAX_KL) : KW'(MAX_KL / 2);
    kl_new = kl_new >> (2'd2 - vlen_i);
  end

  assign bad_cmd = kreg_zero_i | zeroing_i | (vlen_i == VLEN_BAD);

  for (genvar g = 0; g < MAX_KL; g++) begin : g_klm
    assign kl_mask[g] = (kl_q > KW'(g));
  end

  assign live = mask_q & kl_mask;

  vsc_first_set #(.N(MAX_KL)) i_first (
    .vec_i   (live),
    .found_o (any_live),
    .pos_o   (next_pos)
  );

  vsc_elem_path #(.MAX_KL(MAX_KL), .AW(AW)) i_path (
    .elem_i   (elem_q),
    .idx64_i  (idx64_q),
    .elem64_i (elem64_q),
    .scale_i  (scale_q),
    .base_i   (base_q),
    .disp_i   (disp_q),
    .index_i  (index_q),
    .data_i   (data_q),
    .addr_o   (wr_addr_o),
    .data_o   (wr_data_o),
    .be_o     (wr_be_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      elem_q    <= '0;
      felem_q   <= '0;
      mask_q    <= '0;
      kl_q      <= '0;
      base_q    <= '0;
      disp_q    <= '0;
      scale_q   <= '0;
      idx64_q   <= 1'b0;
      elem64_q  <= 1'b0;
      index_q   <= '0;
      data_q    <= '0;
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q    <= 1'b0;
      fault_q   <= 1'b0;
      illegal_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mask_q <= mask_i;
          if (bad_cmd) begin
            illegal_q <= 1'b1;
          end else begin
            kl_q     <= kl_new;
            base_q   <= base_i;
            disp_q   <= disp_i;
            scale_q  <= scale_i;
            idx64_q  <= idx64_i;
            elem64_q <= elem64_i;
            index_q  <= index_i;
            data_q   <= data_i;
            st_q     <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (any_live) begin
            elem_q <= next_pos;
            st_q   <= ST_ISSUE;
          end else begin
            mask_q <= mask_q & kl_mask;  // drops bits at KL and above
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_ISSUE: if (wr_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (rsp_fault_i) begin
            fault_q <= 1'b1;
            felem_q <= elem_q;
            st_q    <= ST_IDLE;
          end else begin
            mask_q[elem_q] <= 1'b0;
            st_q           <= ST_SCAN;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o   = (st_q == ST_ISSUE);
  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_elem_o = felem_q;
  assign illegal_o    = illegal_q;
  assign mask_o       = mask_q;
endmodule

// File: rtl/vscatter_seq_chk.sv
module vscatter_seq_chk #(
  parameter int MAX_KL = 16,
  parameter int AW     = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic              wr_ready_i,
  input logic [AW-1:0]     wr_addr_o,
  input logic [63:0]       wr_data_o,
  input logic [7:0]        wr_be_o,
  input logic              rsp_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              fault_o,
  input logic              illegal_o,
  input logic [MAX_KL-1:0] mask_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       pend_q <= 1'b0;
    else if (wr_valid_o && wr_ready_i) pend_q <= 1'b1;
    else if (rsp_valid_i)              pend_q <= 1'b0;
  end

  assert_one_flight_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> !wr_valid_o);

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o));

  assert_be_shape_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_be_o == 8'h0F && wr_data_o[63:32] == 32'h0) || wr_be_o == 8'hFF);

  assert_done_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> mask_o == '0);

  assert_mask_shrink_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (mask_o & ~$past(mask_o)) == '0);

  assert_one_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fault_o, illegal_o}));

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !wr_valid_o);
endmodule

bind vscatter_seq vscatter_seq_chk #(.MAX_KL(MAX_KL), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_valid_o  (wr_valid_o),
  .wr_ready_i  (wr_ready_i),
  .wr_addr_o   (wr_addr_o),
  .wr_data_o   (wr_data_o),
  .wr_be_o     (wr_be_o),
  .rsp_valid_i (rsp_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .illegal_o   (illegal_o),
  .mask_o      (mask_o)
);

// File: tb/test_vscatter_seq.sv
module test_vscatter_seq;
  localparam int MAX_KL = 16;
  localparam int AW     = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, idx64_i = 0, elem64_i = 0, kreg_zero_i = 0, zeroing_i = 0;
  logic [1:0] vlen_i = 0, scale_i = 0;
  logic [63:0] base_i = 0;
  logic [31:0] disp_i = 0;
  logic [MAX_KL*32-1:0] index_i = '0, data_i = '0;
  logic [MAX_KL-1:0] mask_i = '0;
  logic wr_valid_o, wr_ready_i = 0, rsp_valid_i = 0, rsp_fault_i = 0;
  logic [AW-1:0] wr_addr_o;
  logic [63:0] wr_data_o;
  logic [7:0] wr_be_o;
  logic busy_o, done_o, fault_o, illegal_o;
  logic [3:0] fault_elem_o;
  logic [MAX_KL-1:0] mask_o;

  always #4 clk = ~clk;  // 125 MHz

  vscatter_seq #(.MAX_KL(MAX_KL), .AW(AW)) i_vscatter_seq (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .idx64_i(idx64_i), .elem64_i(elem64_i),
    .vlen_i(vlen_i), .scale_i(scale_i), .kreg_zero_i(kreg_zero_i), .zeroing_i(zeroing_i),
    .base_i(base_i), .disp_i(disp_i), .index_i(index_i), .data_i(data_i), .mask_i(mask_i),
    .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_addr_o(wr_addr_o),
    .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .rsp_valid_i(rsp_valid_i),
    .rsp_fault_i(rsp_fault_i), .busy_o(busy_o), .done_o(done_o), .fault_o(fault_o),
    .fault_elem_o(fault_elem_o), .illegal_o(illegal_o), .mask_o(mask_o));

  int n_chk = 0, n_err = 0, tick = 0;
  // responder controls and write log
  int fault_at = -1;
  bit stall = 0;
  int wr_n = 0;
  logic [AW-1:0] log_a [32];
  logic [63:0]   log_d [32];
  logic [7:0]    log_b [32];
  // command under test
  logic [31:0] iw [16];
  logic [31:0] dw [16];
  bit p_poke = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  initial begin : responder
    bit pend = 0, pend_f = 0;
    forever begin
      @(negedge clk);
      tick++;
      rsp_valid_i = 0;
      rsp_fault_i = 0;
      wr_ready_i = stall ? ((tick % 4) == 3) : 1'b1;
      if (pend) begin
        rsp_valid_i = 1;
        rsp_fault_i = pend_f;
        pend = 0;
      end else if (wr_valid_o && wr_ready_i) begin
        if (wr_n < 32) begin
          log_a[wr_n] = wr_addr_o;
          log_d[wr_n] = wr_data_o;
          log_b[wr_n] = wr_be_o;
        end
        pend_f = (wr_n == fault_at);
        pend = 1;
        wr_n++;
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic fill(input int seed);
    for (int w = 0; w < 16; w++) begin
      iw[w] = 32'(seed) * 32'h0100_0193 + 32'(w) * 32'h9E37_79B1;
      dw[w] = 32'hD000_0000 ^ (32'(seed) << 8) ^ 32'(w);
      index_i[w*32 +: 32] = iw[w];
      data_i[w*32 +: 32]  = dw[w];
    end
  endtask

  task automatic run_op(input bit i64, input bit e64, input logic [1:0] vl,
                        input logic [1:0] sc, input logic [63:0] base,
                        input logic [31:0] disp, input logic [15:0] m,
                        input bit kz, input bit zr, input int f_at, input bit stl);
    int kl, nexp, cyc, felem;
    bit ill, got, s_done, s_fault, s_ill;
    logic [AW-1:0] ea [16];
    logic [63:0] ed [16], ix, full;
    logic [15:0] emask;
    ill = kz || zr || (vl == 2'd3);
    kl = ((!i64 && !e64) ? 16 : 8) >> (2 - ((vl == 2'd3) ? 2 : int'(vl)));
    nexp = 0;
    felem = -1;
    emask = ill ? m : 16'h0;
    if (!ill) begin
      for (int j = 0; j < kl; j++) begin
        if (m[j] && felem < 0) begin
          ix = i64 ? {iw[2*j+1], iw[2*j]} : {{32{iw[j][31]}}, iw[j]};
          full = base + (ix << sc) + {{32{disp[31]}}, disp};
          ea[nexp] = full[AW-1:0];
          ed[nexp] = e64 ? {dw[2*j+1], dw[2*j]} : {32'h0, dw[j]};
          if (nexp == f_at) felem = j;
          nexp++;
        end
      end
      if (felem >= 0) begin
        emask = m;
        for (int j = 0; j < felem; j++) emask[j] = 1'b0;
      end
    end
    fault_at = f_at;
    stall = stl;
    wr_n = 0;
    @(negedge clk);
    idx64_i = i64; elem64_i = e64; vlen_i = vl; scale_i = sc; base_i = base;
    disp_i = disp; mask_i = m; kreg_zero_i = kz; zeroing_i = zr; start_i = 1;
    @(negedge clk);
    start_i = 0;
    cyc = 1;
    if (!ill) chk(busy_o == 1'b1, "R10", "busy after start", 64'(busy_o), 64'd1);
    got = 0;
    while (!got && cyc < 600) begin
      if (done_o || fault_o || illegal_o) begin
        got = 1;
        s_done = done_o; s_fault = fault_o; s_ill = illegal_o;
      end else begin
        if (p_poke && cyc == 3) begin mask_i = ~m; start_i = 1; end
        else if (p_poke && cyc == 4) begin mask_i = m; start_i = 0; end
        @(negedge clk);
        cyc++;
      end
    end
    if (!got) begin s_done = 0; s_fault = 0; s_ill = 0; end
    chk(got, "R4", "op finished", 64'(got), 64'd1);
    if (ill) chk(s_ill, "R8", "illegal pulse", 64'(s_ill), 64'd1);
    else if (felem >= 0) begin
      chk(s_fault, "R7", "fault pulse", 64'(s_fault), 64'd1);
      chk(fault_elem_o == 4'(felem), "R7", "fault element", 64'(fault_elem_o), 64'(felem));
    end else chk(s_done, "R6", "done pulse", 64'(s_done), 64'd1);
    if (!ill && nexp == 0)
      chk(cyc <= 2, "R9", "empty mask latency", 64'(cyc), 64'd2);
    chk(mask_o == emask, ill ? "R8" : (felem >= 0 ? "R7" : "R6"), "final mask",
        64'(mask_o), 64'(emask));
    chk(wr_n == nexp, "R1", "write count", 64'(wr_n), 64'(nexp));
    for (int k = 0; k < nexp && k < wr_n; k++) begin
      chk(log_a[k] == ea[k], "R2", "address", 64'(log_a[k]), 64'(ea[k]));
      chk(log_d[k] == ed[k], "R5", "data", log_d[k], ed[k]);
      chk(log_b[k] == (e64 ? 8'hFF : 8'h0F), "R5", "byte enables",
          64'(log_b[k]), e64 ? 64'hFF : 64'h0F);
    end
    chk(busy_o == 1'b0, "R10", "idle after end", 64'(busy_o), 64'd0);
  endtask

  initial begin : main
    logic [15:0] pats [4];
    pats[0] = 16'hFFFF; pats[1] = 16'h5A3C; pats[2] = 16'h0001; pats[3] = 16'h8000;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R11 reset state
    chk(!busy_o && !done_o && !fault_o && !illegal_o, "R11", "reset flags",
        {60'h0, busy_o, done_o, fault_o, illegal_o}, 64'h0);
    chk(!wr_valid_o, "R11", "reset write valid", 64'(wr_valid_o), 64'd0);
    chk(mask_o == '0, "R11", "reset mask", 64'(mask_o), 64'd0);
    // R1 R2 R3 R4 R5 R6 sweep over all modes, patterns and scales
    for (int i64 = 0; i64 < 2; i64++)
      for (int e64 = 0; e64 < 2; e64++)
        for (int vl = 0; vl < 3; vl++)
          for (int p = 0; p < 4; p++) begin
            fill(i64 * 100 + e64 * 37 + vl * 11 + p);
            run_op(i64[0], e64[0], 2'(vl), 2'(vl + i64 + e64 + p),
                   (p[0] ? 64'hFFFF_FFFF_FFFF_FF00 : 64'h0000_1234_5678_0000),
                   (p[1] ? 32'hFFFF_FFF0 : 32'h0000_0040), pats[p], 0, 0, -1, p[0]);
          end
    // R3 wrap past the top of the address space
    fill(77);
    run_op(0, 1, 2'd2, 2'd3, 64'h0000_00FF_FFFF_FFF8, 32'h10, 16'h00FF, 0, 0, -1, 0);
    // R4 overlapping addresses: all indices equal, element order kept
    fill(5);
    for (int w = 0; w < 16; w++) begin iw[w] = 32'h40; index_i[w*32 +: 32] = 32'h40; end
    run_op(0, 0, 2'd2, 2'd2, 64'h1000, 32'h0, 16'hF0F0, 0, 0, -1, 1);
    // R7 faults on the second write, several modes
    for (int vl = 0; vl < 3; vl++) begin
      fill(300 + vl);
      run_op(0, 0, 2'(vl), 2'd1, 64'h8000, 32'h4, 16'hFFFF, 0, 0, 1, vl == 1);
      fill(400 + vl);
      run_op(1, 1, 2'(vl), 2'd3, 64'h8000, 32'h8, 16'hF0F6, 0, 0, 1, 0);
    end
    // R7 fault on the first write keeps the whole mask
    fill(9);
    run_op(1, 0, 2'd2, 2'd0, 64'h0, 32'h0, 16'h3C3C, 0, 0, 0, 0);
    // R9 empty mask below KL, upper bits set
    fill(11);
    run_op(0, 0, 2'd0, 2'd0, 64'h0, 32'h0, 16'hFFF0, 0, 0, -1, 0);
    run_op(1, 1, 2'd1, 2'd0, 64'h0, 32'h0, 16'h0000, 0, 0, -1, 0);
    // R8 illegal encodings
    run_op(0, 0, 2'd2, 2'd0, 64'h0, 32'h0, 16'hBEEF, 1, 0, -1, 0);
    run_op(0, 0, 2'd2, 2'd0, 64'h0, 32'h0, 16'h1234, 0, 1, -1, 0);
    run_op(1, 0, 2'd3, 2'd0, 64'h0, 32'h0, 16'h00F0, 0, 0, -1, 0);
    // R10 start while busy ignored
    fill(21);
    p_poke = 1;
    run_op(0, 0, 2'd2, 2'd2, 64'h2000, 32'h0, 16'hFFFF, 0, 0, -1, 1);
    p_poke = 0;
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule